// File: doc/BRIEF.md
# Synchronous Burst Bus Target

This block is the FPGA side of a memory-mapped link to a microcontroller. The host supplies a free-running clock and, on the same edge, a select line, a direction line and one shared address/data word. All inputs are sampled directly on that clock. Because nothing crosses into another clock domain, no resynchronizers are needed. A transfer opens with one address beat. Each later clock cycle with select still high moves one data word while an internal pointer steps through a small word array.

The host holds its control lines steady for the whole burst. The target therefore treats the fall of select as the only end-of-burst marker, and an access of one word is simply a burst of length one. Reads reach the first word one clock after the address beat. The read-data path is enabled only while the target is actually answering a read. A wait output can stall the host on a configurable not-ready window of the array. That window is disabled by default, so in the default build the wait output stays low.

Top module: `sbus_target`

## Requirements
- R1: After reset every word of the array reads as zero, and `rd_oe_o`, `rd_o` and `wait_o` are low.
- R2: The first cycle with `sel_i` high after a cycle with it low is the address beat. Its `ad_i` gives the start word, of which only the low log2(DEPTH) bits are decoded. With the defaults (DEPTH 64), address 0x0045 and address 0xFF05 both reach word 5.
- R3: In a write burst, each cycle after the address beat with `sel_i` high stores `ad_i` into one word, at consecutive word addresses starting at the start word.
- R4: In a read burst, the word at the start address is on `rd_o` in the cycle right after the address beat. Each later cycle with `sel_i` high presents the next word.
- R5: The burst pointer wraps from word DEPTH-1 to word 0, for both reads and writes.
- R6: `rd_oe_o` is high only while `sel_i` is high, the burst is a read and the address beat has passed. It is low during the address beat and throughout write bursts. Whenever `rd_oe_o` is low, `rd_o` is zero.
- R7: Driving `sel_i` low for one cycle ends a burst, and the next cycle with `sel_i` high is a fresh address beat.
- R8: With the not-ready window disabled (default), `wait_o` never rises. With it enabled, every data beat whose word lies in the window is stretched by SLOW_WAIT cycles of `wait_o` high. During those cycles no word is written, the pointer holds and `rd_o` holds.
- R9: The direction is taken from `wr_i` on the address beat only. A change of `wr_i` during the data beats has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied free-running bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Select, high for the duration of one burst |
| wr_i | input | 1 | Direction on the address beat: 1 write, 0 read |
| ad_i | input | DW | Shared word: start address on the address beat, write data afterwards |
| rd_o | output | DW | Read data word, zero when not enabled |
| rd_oe_o | output | 1 | Enable for driving the shared lines with `rd_o` |
| wait_o | output | 1 | High when the current data beat is stalled |

## Verification
The hardest case to reach is the stall: the not-ready window only exists when a parameter enables it. The bench therefore builds a second instance with a four-word window and a host model that holds each beat while `wait_o` is high. It then writes and reads a burst that straddles the window edge and counts the wait cycles. Pointer wrap and address aliasing come from table bursts that start near the top of the array and above it.

// File: rtl/sbus_pkg.sv
// Shared types and helpers for the synchronous burst bus target.
// Assumes all users run on the single host-supplied bus clock.
package sbus_pkg;

    // Burst phase: waiting for an address beat, or moving data words.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // True when word index a lies inside the inclusive window [lo, hi].
    function automatic logic in_window(input int a, input int lo, input int hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/sbus_seq.sv
// Burst sequencer: recognises the address beat, latches direction and start
// word, advances the word pointer once per accepted data beat, and issues
// write and read-prefetch strobes to the array.
// Assumes select drops for at least one cycle between bursts.
module sbus_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic          stall_i,
    output logic          data_ph_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          rd_ld_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] ptr_o,
    output logic          oe_o
);
    import sbus_pkg::*;

    phase_e        phase_q;
    logic          dir_wr_q;
    logic [AW-1:0] ptr_q;
    logic          addr_beat;
    logic          data_beat;
    logic [AW-1:0] ptr_inc;

    // Classify the current cycle and derive the next pointer value.
    always_comb begin
        addr_beat = sel_i && (phase_q == PH_IDLE);
        data_beat = sel_i && (phase_q == PH_DATA) && !stall_i;
        ptr_inc   = ptr_q + AW'(1);
    end

    // Phase, direction and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            dir_wr_q <= 1'b0;
            ptr_q    <= '0;
        end else begin
            phase_q <= sel_i ? PH_DATA : PH_IDLE;
            if (addr_beat) begin
                dir_wr_q <= wr_i;
                ptr_q    <= addr_i;
            end else if (data_beat) begin
                ptr_q <= ptr_inc;
            end
        end
    end

    // Strobes to the array and the read-enable qualifier.
    always_comb begin
        data_ph_o = sel_i && (phase_q == PH_DATA);
        wr_en_o   = data_beat && dir_wr_q;
        wr_addr_o = ptr_q;
        rd_ld_o   = (addr_beat && !wr_i) || (data_beat && !dir_wr_q);
        rd_addr_o = addr_beat ? addr_i : ptr_inc;
        ptr_o     = ptr_q;
        oe_o      = data_ph_o && !dir_wr_q;
    end

endmodule

// File: rtl/sbus_wait.sv
// Not-ready window stall generator: when enabled, each data beat whose word
// lies in [SLOW_LO, SLOW_HI] is held for SLOW_WAIT cycles before it counts.
// Assumes the window bounds are valid word indices when SLOW_EN is set.
module sbus_wait #(
    parameter int AW        = 6,
    parameter bit SLOW_EN   = 1'b0,
    parameter int SLOW_LO   = 0,
    parameter int SLOW_HI   = 0,
    parameter int SLOW_WAIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic [AW-1:0] ptr_i,
    output logic          stall_o
);
    import sbus_pkg::*;

    localparam int CW = (SLOW_WAIT < 2) ? 1 : $clog2(SLOW_WAIT + 1);

    logic [CW-1:0] cnt_q;
    logic          hit;

    // Decide whether the present beat must be held.
    always_comb begin
        hit     = SLOW_EN && in_window(int'(ptr_i), SLOW_LO, SLOW_HI);
        stall_o = active_i && hit && (cnt_q != CW'(SLOW_WAIT));
    end

    // Count wait cycles of the present beat; clear once it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (stall_o) begin
            cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/sbus_array.sv
// Word array with one write port and one registered read port. Each word is
// its own reset register so the array powers up cleared.
// Assumes DEPTH is a power of two so every pointer value selects a word.
module sbus_array #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_ld_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);
    logic [DW-1:0] word_all [DEPTH];
    logic [DW-1:0] rd_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] q;
        // Store one word when the write strobe selects this index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en_i && (wr_addr_i == AW'(g))) begin
                q <= wr_data_i;
            end
        end
        assign word_all[g] = q;
    end

    // Registered read port, loaded on address beat or accepted read beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_ld_i) begin
            rd_q <= word_all[rd_addr_i];
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/sbus_target.sv
// Synchronous burst bus target: a host-clocked word array reached by
// address-first bursts over a shared address/data word.
// Assumes every input is synchronous to clk and DW >= log2(DEPTH).
module sbus_target #(
    parameter int DW        = 16,
    parameter int DEPTH     = 64,
    parameter bit SLOW_EN   = 1'b0,
    parameter int SLOW_LO   = 0,
    parameter int SLOW_HI   = 0,
    parameter int SLOW_WAIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] rd_o,
    output logic          rd_oe_o,
    output logic          wait_o
);
    localparam int AW = $clog2(DEPTH);

    logic          data_ph;
    logic          stall;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_ld;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] ptr;
    logic          oe;
    logic [DW-1:0] rd_word;

    sbus_seq #(.AW(AW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel_i),
        .wr_i     (wr_i),
        .addr_i   (ad_i[AW-1:0]),
        .stall_i  (stall),
        .data_ph_o(data_ph),
        .wr_en_o  (wr_en),
        .wr_addr_o(wr_addr),
        .rd_ld_o  (rd_ld),
        .rd_addr_o(rd_addr),
        .ptr_o    (ptr),
        .oe_o     (oe)
    );

    sbus_wait #(
        .AW       (AW),
        .SLOW_EN  (SLOW_EN),
        .SLOW_LO  (SLOW_LO),
        .SLOW_HI  (SLOW_HI),
        .SLOW_WAIT(SLOW_WAIT)
    ) wait_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(data_ph),
        .ptr_i   (ptr),
        .stall_o (stall)
    );

    sbus_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(ad_i),
        .rd_ld_i  (rd_ld),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_word)
    );

    // Drive read data only while the read enable is up.
    always_comb begin
        rd_oe_o = oe;
        rd_o    = oe ? rd_word : '0;
        wait_o  = stall;
    end

endmodule

// File: rtl/sbus_target_chk.sv
// Port-level protocol checker for sbus_target, attached by bind.
// Assumes reset is held low from time zero until the first burst.
module sbus_target_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_i,
    input logic          wr_i,
    input logic [DW-1:0] rd_o,
    input logic          rd_oe_o,
    input logic          wait_o
);
    // R6: no read enable without select
    a_r6_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> !rd_oe_o);

    // R6: data lines zero while enable is low
    a_r6_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe_o |-> (rd_o == '0));

    // R4: a read address beat is followed by enabled data while selected
    a_r4_read_enable_next: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_i) && !wr_i) |=> (!sel_i || rd_oe_o));

    // R9: a write address beat never enables read data next cycle
    a_r9_write_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel_i) && wr_i) |=> !rd_oe_o);

    // R8: wait only during a data beat of an open burst
    a_r8_wait_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (sel_i && $past(sel_i)));

    // R8: read data held across a stalled beat
    a_r8_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && rd_oe_o) |=> (!sel_i || $stable(rd_o)));

endmodule

bind sbus_target sbus_target_chk #(.DW(DW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .rd_o   (rd_o),
    .rd_oe_o(rd_oe_o),
    .wait_o (wait_o)
);

// File: tb/sbus_target_tb_top.sv
module sbus_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 64;
    localparam int SW    = 2;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  len;
        logic [15:0] seed;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0003, 8'd1, 16'hA100},
        '{1'b1, 16'h0010, 8'd5, 16'h1200},
        '{1'b1, 16'h003E, 8'd4, 16'h3E00},
        '{1'b0, 16'h0010, 8'd5, 16'h0000},
        '{1'b1, 16'h0045, 8'd2, 16'h4500},
        '{1'b0, 16'h003C, 8'd8, 16'h0000},
        '{1'b0, 16'hFF05, 8'd1, 16'h0000},
        '{1'b0, 16'h0003, 8'd3, 16'h0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_i = 1'b0, wr_i = 1'b0;
    logic [DW-1:0] ad_i = '0;
    logic [DW-1:0] rd_o;
    logic          rd_oe_o, wait_o;
    logic          s_sel = 1'b0, s_wr = 1'b0;
    logic [DW-1:0] s_ad = '0;
    logic [DW-1:0] s_rd;
    logic          s_oe, s_wait;

    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] s_ref [DEPTH];
    int checks = 0;
    int failures = 0;
    int wait_seen = 0;
    int s_waits = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbus_target #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .ad_i(ad_i),
        .rd_o(rd_o), .rd_oe_o(rd_oe_o), .wait_o(wait_o)
    );

    sbus_target #(.DW(DW), .DEPTH(DEPTH), .SLOW_EN(1'b1), .SLOW_LO(8),
                  .SLOW_HI(11), .SLOW_WAIT(SW)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .sel_i(s_sel), .wr_i(s_wr), .ad_i(s_ad),
        .rd_o(s_rd), .rd_oe_o(s_oe), .wait_o(s_wait)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R8 default build: monitor wait on the plain instance
    always begin
        @(posedge clk);
        #2;
        if (rst_n && wait_o) wait_seen++;
    end

    task automatic burst_write(input logic [15:0] a, input int n,
                               input logic [15:0] seed, input bit flip);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b1; ad_i = a;
        #1 check(!rd_oe_o, "R6 enable low on address beat", rd_oe_o, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ad_i = seed + 16'(i) * 16'h0111;
            wr_i = (flip && i > 0) ? 1'b0 : 1'b1;
            ref_mem[(int'(a) + i) % DEPTH] = ad_i;
            #1 check(!rd_oe_o, "R9 enable low in write data phase", rd_oe_o, 0);
        end
        @(negedge clk);
        sel_i = 1'b0; wr_i = 1'b0; ad_i = '0;
    endtask

    task automatic burst_read(input logic [15:0] a, input int n, input string tag);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b0; ad_i = a;
        #1 check(!rd_oe_o && rd_o == 0, "R6 enable low on read address beat", rd_oe_o, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ad_i = 16'hDEAD;
            #1;
            check(rd_oe_o == 1'b1, "R6 enable high in read data phase", rd_oe_o, 1);
            check(rd_o == ref_mem[(int'(a) + i) % DEPTH], tag,
                  rd_o, ref_mem[(int'(a) + i) % DEPTH]);
        end
        @(negedge clk);
        sel_i = 1'b0; ad_i = '0;
        #1 check(!rd_oe_o && rd_o == 0, "R7 burst ends, outputs off", rd_o, 0);
    endtask

    task automatic slow_write(input logic [15:0] a, input int n, input logic [15:0] seed);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b1; s_ad = a;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_ad = seed + 16'(i);
            s_ref[(int'(a) + i) % DEPTH] = s_ad;
            #1;
            while (s_wait) begin
                s_waits++;
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        s_sel = 1'b0; s_wr = 1'b0; s_ad = '0;
    endtask

    task automatic slow_read(input logic [15:0] a, input int n);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b0; s_ad = a;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            while (s_wait) begin
                s_waits++;
                check(s_rd == s_ref[(int'(a) + i) % DEPTH], "R8 data held during wait",
                      s_rd, s_ref[(int'(a) + i) % DEPTH]);
                @(negedge clk);
                #1;
            end
            check(s_rd == s_ref[(int'(a) + i) % DEPTH], "R8 read through window",
                  s_rd, s_ref[(int'(a) + i) % DEPTH]);
        end
        @(negedge clk);
        s_sel = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '0;
            s_ref[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check(!rd_oe_o && rd_o == 0 && !wait_o, "R1 outputs low in reset",
                 {rd_oe_o, wait_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(!rd_oe_o && !wait_o, "R1 outputs low after reset", {rd_oe_o, wait_o}, 0);
        burst_read(16'h0000, 4, "R1 array cleared by reset");

        // Table-driven mixed single and burst traffic (R2 R3 R4 R5 R7)
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr)
                burst_write(VECS[v].addr, int'(VECS[v].len), VECS[v].seed, 1'b0);
            else
                burst_read(VECS[v].addr, int'(VECS[v].len),
                           $sformatf("R2/R3/R4/R5 table vector %0d", v));
        end

        // R9: direction line toggled mid write burst is ignored
        burst_write(16'h0020, 3, 16'h7700, 1'b1);
        burst_read(16'h0020, 3, "R9 direction latched on address beat");

        // R7: single write then single read with one idle cycle between
        burst_write(16'h0030, 1, 16'h5A5A, 1'b0);
        burst_read(16'h0030, 1, "R7 single access after single access");

        // R5: wrap on a burst that spans the whole array plus one
        burst_read(16'h003F, DEPTH + 1, "R5 full wrap read");

        // R8: default build never stalls
        check(wait_seen == 0, "R8 wait low in default build", wait_seen, 0);

        // R8: enabled window stalls beats at words 8 and 9
        s_waits = 0;
        slow_write(16'h0006, 4, 16'hC000);
        check(s_waits == 2 * SW, "R8 wait cycles on write", s_waits, 2 * SW);
        s_waits = 0;
        slow_read(16'h0006, 4);
        check(s_waits == 2 * SW, "R8 wait cycles on read", s_waits, 2 * SW);
        slow_read(16'h0004, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule